// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two raw lines of a low-speed USB link into a stream of received bytes. It runs from a 16 MHz system clock. That clock is not a whole multiple of the 1.5 Mbit/s line rate, because one bit lasts 10⅔ clocks. Both lines pass through a two-flop synchroniser. While the bus is idle the receiver waits. It then follows the alternating start-of-packet pattern and moves its sampling point to every J-to-K transition it sees. It enters the data phase once two consecutive bit-centre samples read K.

In the data phase, each bit-centre sample is NRZI-decoded. The zero that the transmitter inserts after six ones is removed. The remaining bits are packed least significant bit first, and every finished byte appears for one clock on the byte outputs. A single-ended zero at a sample point ends the packet. At that moment the block reports the byte count and a good/bad verdict. A packet is bad when it overflows the byte limit, breaks the stuffing rule, or ends part-way through a byte. The consumer discards a bad packet. CRC, PID meaning and endpoint handling are left to downstream logic.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, `rx_valid` and `pkt_done` are low, and `pkt_good`, `pkt_overflow`, `pkt_stuff_err` and `pkt_bytes` are zero.
- R2: The line state is taken as {D+, D-} after a two-flop synchroniser. J is {0,1} and is the idle state. K is {1,0}. SE0 is {0,0}.
- R3: Each J-to-K transition seen before the data phase re-centres the sampling point. The data phase starts only after two consecutive bit-centre samples read K. A K pulse that has gone by the bit centre, or a start pattern that stops before the double K, produces no byte and no `pkt_done`.
- R4: After a re-centre, the first sample is taken SAMPLE_OFS+1 clocks in. Later samples are spaced 10, 11, 11 clocks in rotation, so every three bit times span exactly 32 clocks. A maximum-length packet sent at the nominal rate decodes without error.
- R5: NRZI decoding yields 1 when the line state equals the previous sample and 0 when it has toggled. The first data bit is compared with the final K of the start pattern.
- R6: The bit time that follows six consecutive decoded ones is discarded. If that bit decodes as 1 (a seventh one), `pkt_stuff_err` is set and `pkt_good` is low.
- R7: During the data phase, an SE0 at a sample point ends the packet. `pkt_done` pulses for one clock, and `pkt_bytes` gives the number of bytes delivered. `pkt_good` is high only if there was no overflow, no stuffing error and no leftover partial byte.
- R8: Data bits are packed LSB first. Each completed byte is presented on `rx_data` with a one-clock `rx_valid`, in arrival order, and only during the data phase.
- R9: Bytes beyond MAX_BYTES (default 11) are not delivered. In that case `pkt_overflow` is set, `pkt_good` is low and `pkt_bytes` equals MAX_BYTES.
- R10: After a packet ends, or after an SE0 during the start pattern, the receiver waits for idle J and then for a new start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | Raw D+ line, asynchronous |
| usb_dm | input | 1 | Raw D- line, asynchronous |
| rx_valid | output | 1 | One-clock strobe: `rx_data` holds a received byte |
| rx_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-clock strobe at end of packet |
| pkt_good | output | 1 | Packet verdict, updated with `pkt_done` |
| pkt_bytes | output | LEN_W | Bytes delivered in the packet, updated with `pkt_done` |
| pkt_overflow | output | 1 | Packet exceeded MAX_BYTES, updated with `pkt_done` |
| pkt_stuff_err | output | 1 | Seven consecutive ones seen, updated with `pkt_done` |

## Verification
The assertions check the following on every clock:
- consecutive sample ticks are 10 or 11 clocks apart;
- the decoder's run of ones never exceeds six;
- the byte and end-of-packet strobes last one clock;
- bytes appear only in the data phase;
- the data phase is entered only from a K sample;
- the reported count never exceeds the limit.

Only the bench scenarios show the end-to-end results. These are correct bytes after long packets at the fractional bit rate, rejection of glitches and truncated start patterns, removal of stuffed bits, and the verdicts for overflow, stuffing errors and partial bytes.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types and constants for the low-speed receiver.
// Assumes line states are encoded as {D+, D-}.
package usb_ls_rx_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        FR_IDLE = 2'b00,
        FR_SYNC = 2'b01,
        FR_DATA = 2'b10
    } frame_e;

    // Decoded ones after which the transmitter inserts a zero
    localparam logic [2:0] STUFF_RUN = 3'd6;

endpackage

// File: rtl/usb_ls_line_sync.sv
// Two-flop synchroniser for D+/D- plus a J-to-K transition detector.
// Assumes the raw lines are asynchronous to clk. Reset value is idle J.
module usb_ls_line_sync
    import usb_ls_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_raw,
    input  logic  dm_raw,
    output line_e line,
    output logic  kedge
);

    logic [1:0] meta_q;
    logic [1:0] sync_q;
    logic [1:0] hist_q;

    // Synchronise the raw lines and keep one older copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= LN_J;
            sync_q <= LN_J;
            hist_q <= LN_J;
        end else begin
            meta_q <= {dp_raw, dm_raw};
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Present the synchronised state and flag a fresh J-to-K transition
    always_comb begin
        line  = line_e'(sync_q);
        kedge = (sync_q == LN_K) && (hist_q == LN_J);
    end

endmodule

// File: rtl/usb_ls_bit_timer.sv
// Fractional bit timer: emits one sample tick per bit time of NUM/DEN clocks.
// Assumes realign marks the clock after a bit edge. Ticks only while armed.
module usb_ls_bit_timer #(
    parameter int NUM = 32,
    parameter int DEN = 3,
    parameter int OFS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic realign,
    output logic tick
);

    localparam int BASE  = NUM / DEN;
    localparam int REM   = NUM % DEN;
    localparam int CNT_W = $clog2(BASE + 2);
    localparam int ACC_W = $clog2(2 * DEN);
    localparam logic [ACC_W-1:0] DEN_A   = ACC_W'(DEN);
    localparam logic [ACC_W-1:0] REM_A   = ACC_W'(REM);
    localparam logic [CNT_W-1:0] LONG_M1 = CNT_W'(BASE);
    localparam logic [CNT_W-1:0] SHRT_M1 = CNT_W'(BASE - 1);
    localparam logic [CNT_W-1:0] OFS_C   = CNT_W'(OFS);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             leap;

    // Decide whether this bit time takes the extra clock
    always_comb begin
        acc_sum = acc_q + REM_A;
        leap    = (acc_sum >= DEN_A);
        tick    = armed && (cnt_q == '0);
    end

    // Count down to the next sample point and carry the fractional remainder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (realign) begin
            cnt_q <= OFS_C;
            acc_q <= '0;
        end else if (!armed) begin
            cnt_q <= cnt_q;
        end else if (tick) begin
            cnt_q <= leap ? LONG_M1 : SHRT_M1;
            acc_q <= leap ? (acc_sum - DEN_A) : acc_sum;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Checker state: clocks elapsed since the previous tick
    logic [CNT_W:0] gap_q;
    logic           ref_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            ref_q <= 1'b0;
        end else if (realign) begin
            gap_q <= '0;
            ref_q <= 1'b0;
        end else if (tick) begin
            gap_q <= '0;
            ref_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R4: ticks with no re-centre between them are BASE or BASE+1 clocks apart
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ref_q && !realign) |->
            ((gap_q == (CNT_W+1)'(BASE - 1)) || (gap_q == (CNT_W+1)'(BASE))));

endmodule

// File: rtl/usb_ls_framer.sv
// Packet framing control: idle wait, start-pattern tracking, data phase.
// Assumes a tick arrives at each bit centre once armed.
module usb_ls_framer
    import usb_ls_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_e line,
    input  logic  kedge,
    input  logic  tick,
    output logic  armed,
    output logic  realign,
    output logic  start,
    output logic  data_tick,
    output logic  in_data
);

    frame_e st_q;
    logic   prevk_q;

    // Combinational controls derived from the phase and the current sample
    always_comb begin
        realign   = kedge && (st_q == FR_SYNC);
        start     = tick && (st_q == FR_SYNC) && prevk_q && (line == LN_K);
        data_tick = tick && (st_q == FR_DATA);
        in_data   = (st_q == FR_DATA);
    end

    // Move between idle, start-pattern and data phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= FR_IDLE;
            armed   <= 1'b0;
            prevk_q <= 1'b0;
        end else begin
            case (st_q)
                FR_IDLE: begin
                    armed   <= 1'b0;
                    prevk_q <= 1'b0;
                    if (line == LN_J) st_q <= FR_SYNC;
                end
                FR_SYNC: begin
                    if (kedge) armed <= 1'b1;
                    if (tick) begin
                        if (line == LN_SE0) begin
                            st_q  <= FR_IDLE;
                            armed <= 1'b0;
                        end else if (line == LN_K) begin
                            if (prevk_q) st_q <= FR_DATA;
                            prevk_q <= 1'b1;
                        end else begin
                            prevk_q <= 1'b0;
                        end
                    end
                end
                FR_DATA: begin
                    if (tick && (line == LN_SE0)) begin
                        st_q  <= FR_IDLE;
                        armed <= 1'b0;
                    end
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

    // R3: the data phase begins only right after a K sample
    p_enter_on_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data) |-> ($past(line) == LN_K));

    // R10: data phase is left only for the idle phase
    p_exit_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_data) |-> (st_q == FR_IDLE));

endmodule

// File: rtl/usb_ls_decoder.sv
// NRZI decode, stuffed-bit removal, LSB-first byte packing and packet verdict.
// Assumes start pulses once per packet and data_tick marks each bit centre.
module usb_ls_decoder
    import usb_ls_rx_pkg::*;
#(
    parameter int MAX_BYTES = 11,
    parameter int LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             data_tick,
    input  line_e            line,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             pkt_done,
    output logic             pkt_good,
    output logic [LEN_W-1:0] pkt_bytes,
    output logic             pkt_overflow,
    output logic             pkt_stuff_err
);

    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

    logic             prev_dm_q;
    logic [7:0]       shreg_q;
    logic [2:0]       bitpos_q;
    logic [2:0]       ones_q;
    logic [LEN_W-1:0] nbytes_q;
    logic             ovf_q;
    logic             serr_q;

    logic       bit_val;
    logic       stuff_slot;
    logic       byte_end;
    logic       is_eop;
    logic [7:0] next_byte;

    // Decode the current sample against the previous line level
    always_comb begin
        bit_val    = (line[0] == prev_dm_q);
        stuff_slot = (ones_q == STUFF_RUN);
        byte_end   = (bitpos_q == 3'd7);
        is_eop     = (line == LN_SE0);
        next_byte  = {bit_val, shreg_q[7:1]};
    end

    // Bit-level path: NRZI history, stuffing run and byte shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dm_q <= 1'b0;
            shreg_q   <= '0;
            bitpos_q  <= '0;
            ones_q    <= '0;
            serr_q    <= 1'b0;
        end else if (start) begin
            prev_dm_q <= 1'b0;
            shreg_q   <= '0;
            bitpos_q  <= '0;
            ones_q    <= '0;
            serr_q    <= 1'b0;
        end else if (data_tick && !is_eop) begin
            prev_dm_q <= line[0];
            if (stuff_slot) begin
                ones_q <= '0;
                if (bit_val) serr_q <= 1'b1;
            end else begin
                shreg_q  <= next_byte;
                ones_q   <= bit_val ? (ones_q + 1'b1) : 3'd0;
                bitpos_q <= bitpos_q + 1'b1;
            end
        end
    end

    // Byte-level path: deliver completed bytes and track the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            nbytes_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                nbytes_q <= '0;
                ovf_q    <= 1'b0;
            end else if (data_tick && !is_eop && !stuff_slot && byte_end) begin
                if (nbytes_q < MAX_L) begin
                    rx_valid <= 1'b1;
                    rx_data  <= next_byte;
                    nbytes_q <= nbytes_q + 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    // End-of-packet report on SE0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_done      <= 1'b0;
            pkt_good      <= 1'b0;
            pkt_bytes     <= '0;
            pkt_overflow  <= 1'b0;
            pkt_stuff_err <= 1'b0;
        end else begin
            pkt_done <= 1'b0;
            if (data_tick && is_eop) begin
                pkt_done      <= 1'b1;
                pkt_good      <= !ovf_q && !serr_q && (bitpos_q == 3'd0);
                pkt_bytes     <= nbytes_q;
                pkt_overflow  <= ovf_q;
                pkt_stuff_err <= serr_q;
            end
        end
    end

    // R6: the run of ones never exceeds the stuffing length
    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= STUFF_RUN);

    // R7: end-of-packet is a single-clock strobe
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R8: each byte strobe lasts one clock
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: reported count never exceeds the limit
    p_byte_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_bytes <= MAX_L));

endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed USB packet receiver top: synchroniser, fractional bit timer,
// framing control and decoder. Assumes a 16 MHz clk for a 1.5 Mbit/s line.
module usb_ls_rx #(
    parameter int BIT_NUM    = 32,
    parameter int BIT_DEN    = 3,
    parameter int SAMPLE_OFS = 4,
    parameter int MAX_BYTES  = 11,
    parameter int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_dp,
    input  logic             usb_dm,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             pkt_done,
    output logic             pkt_good,
    output logic [LEN_W-1:0] pkt_bytes,
    output logic             pkt_overflow,
    output logic             pkt_stuff_err
);
    import usb_ls_rx_pkg::*;

    line_e line;
    logic  kedge;
    logic  armed;
    logic  realign;
    logic  tick;
    logic  start;
    logic  data_tick;
    logic  in_data;

    usb_ls_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dp_raw (usb_dp),
        .dm_raw (usb_dm),
        .line   (line),
        .kedge  (kedge)
    );

    usb_ls_bit_timer #(
        .NUM (BIT_NUM),
        .DEN (BIT_DEN),
        .OFS (SAMPLE_OFS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .realign (realign),
        .tick    (tick)
    );

    usb_ls_framer u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (line),
        .kedge     (kedge),
        .tick      (tick),
        .armed     (armed),
        .realign   (realign),
        .start     (start),
        .data_tick (data_tick),
        .in_data   (in_data)
    );

    usb_ls_decoder #(
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W)
    ) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .data_tick     (data_tick),
        .line          (line),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .pkt_done      (pkt_done),
        .pkt_good      (pkt_good),
        .pkt_bytes     (pkt_bytes),
        .pkt_overflow  (pkt_overflow),
        .pkt_stuff_err (pkt_stuff_err)
    );

    // R8: bytes are delivered only from samples taken in the data phase
    p_byte_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(in_data));

endmodule

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 11;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0;
    logic       dm = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       pkt_done;
    logic       pkt_good;
    logic [3:0] pkt_bytes;
    logic       pkt_overflow;
    logic       pkt_stuff_err;

    usb_ls_rx u0 (
        .clk (clk), .rst_n (rst_n), .usb_dp (dp), .usb_dm (dm),
        .rx_valid (rx_valid), .rx_data (rx_data), .pkt_done (pkt_done),
        .pkt_good (pkt_good), .pkt_bytes (pkt_bytes),
        .pkt_overflow (pkt_overflow), .pkt_stuff_err (pkt_stuff_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Monitor: record delivered bytes and packet reports away from the edge
    logic [7:0] got [0:1023];
    int  got_n = 0;
    int  done_n = 0;
    bit  d_good, d_ovf, d_serr;
    int  d_bytes;
    always @(negedge clk) begin
        if (rx_valid) begin
            got[got_n % 1024] = rx_data;
            got_n++;
        end
        if (pkt_done) begin
            done_n++;
            d_good  = pkt_good;
            d_ovf   = pkt_overflow;
            d_serr  = pkt_stuff_err;
            d_bytes = int'(pkt_bytes);
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected fewer than %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Line-level transmit model: J=2'b01, K=2'b10, SE0=2'b00 as {dp,dm}
    logic [1:0] lv [0:511];
    int         nl;
    logic       tx_cur;
    int         tx_ones;
    bit         tx_bad;
    logic [7:0] tx_data [0:31];

    task automatic push_lv(input logic [1:0] s);
        lv[nl] = s;
        nl++;
    endtask

    // NRZI-encode one data bit with stuffing; optionally break one stuff slot
    task automatic push_bit(input logic b);
        if (!b) tx_cur = ~tx_cur;
        tx_ones = b ? tx_ones + 1 : 0;
        push_lv(tx_cur ? 2'b01 : 2'b10);
        if (tx_ones == 6) begin
            if (tx_bad) tx_bad = 1'b0;
            else tx_cur = ~tx_cur;
            push_lv(tx_cur ? 2'b01 : 2'b10);
            tx_ones = 0;
        end
    endtask

    // Drive the built levels at 32 clocks per 3 bits, then idle J
    task automatic drive_lv();
        for (int k = 0; k < nl; k++) begin
            {dp, dm} = lv[k];
            repeat (((k + 1) * 32) / 3 - (k * 32) / 3) @(negedge clk);
        end
        {dp, dm} = 2'b01;
        repeat (40) @(negedge clk);
    endtask

    task automatic hold(input logic [1:0] s, input int n);
        {dp, dm} = s;
        repeat (n) @(negedge clk);
    endtask

    // Send a full packet and check every reported value against the model
    task automatic send_pkt(input int n, input bit bad_stuff, input int extra,
                            input string req);
        int base_b = got_n;
        int base_d = done_n;
        int exp_n  = (n > MAXB) ? MAXB : n;
        bit exp_ovf = (n > MAXB);
        bit exp_good = !exp_ovf && !bad_stuff && (extra == 0);
        int mism = 0;
        nl = 0; tx_ones = 0; tx_bad = bad_stuff;
        hold(2'b01, 20);
        for (int i = 0; i < 8; i++) push_lv((i == 7 || i % 2 == 0) ? 2'b10 : 2'b01);
        tx_cur = 1'b0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) push_bit(tx_data[i][b]);
        for (int i = 0; i < extra; i++) push_bit(1'($urandom_range(0, 1)));
        push_lv(2'b00); push_lv(2'b00); push_lv(2'b01);
        drive_lv();
        chk(done_n - base_d == 1, req, "end-of-packet strobes", done_n - base_d, 1);
        chk(got_n - base_b == exp_n, req, "bytes delivered", got_n - base_b, exp_n);
        for (int i = 0; i < exp_n && i < got_n - base_b; i++)
            if (got[(base_b + i) % 1024] != tx_data[i]) mism++;
        chk(mism == 0, req, "byte values mismatched", mism, 0);
        chk(d_bytes == exp_n, req, "pkt_bytes", d_bytes, exp_n);
        chk(d_good == exp_good, req, "pkt_good", int'(d_good), int'(exp_good));
        chk(d_ovf == exp_ovf, req, "pkt_overflow", int'(d_ovf), int'(exp_ovf));
        chk(d_serr == bad_stuff, req, "pkt_stuff_err", int'(d_serr), int'(bad_stuff));
    endtask

    // Expect no byte and no packet report from the preceding stimulus
    task automatic expect_quiet(input int base_b, input int base_d, input string req,
                                input string what);
        chk(got_n == base_b, req, {what, " bytes"}, got_n - base_b, 0);
        chk(done_n == base_d, req, {what, " reports"}, done_n - base_d, 0);
    endtask

    initial begin
        int bb, bd, len;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!rx_valid && !pkt_done, "R1", "strobes in reset", int'(rx_valid | pkt_done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pkt_good && pkt_bytes == 0 && !pkt_overflow && !pkt_stuff_err,
            "R1", "report fields after reset", int'(pkt_bytes), 0);

        // R3: short K glitch gone by the bit centre
        bb = got_n; bd = done_n;
        hold(2'b01, 30); hold(2'b10, 2); hold(2'b01, 200);
        expect_quiet(bb, bd, "R3", "glitch");

        // R3: start pattern stopped before the double K
        bb = got_n; bd = done_n;
        for (int i = 0; i < 5; i++) begin
            hold(2'b10, 11); hold(2'b01, 10);
        end
        hold(2'b01, 300);
        expect_quiet(bb, bd, "R3", "truncated start");

        // R10: SE0 in the start pattern returns to hunting, then a packet works
        bb = got_n; bd = done_n;
        hold(2'b10, 11); hold(2'b01, 10); hold(2'b10, 11); hold(2'b00, 22); hold(2'b01, 40);
        expect_quiet(bb, bd, "R10", "SE0 in start");
        tx_data[0] = 8'hA5; tx_data[1] = 8'h3C;
        send_pkt(2, 1'b0, 0, "R10");

        // R7: empty packet is good with zero bytes
        send_pkt(0, 1'b0, 0, "R7");

        // R2 R5 R8: line coding, NRZI and bit order with asymmetric bytes
        tx_data[0] = 8'h01; tx_data[1] = 8'h80; tx_data[2] = 8'h00; tx_data[3] = 8'hC3;
        send_pkt(4, 1'b0, 0, "R5");
        send_pkt(4, 1'b0, 0, "R8");
        tx_data[0] = 8'h2D; tx_data[1] = 8'h00;
        send_pkt(2, 1'b0, 0, "R2");

        // R6: heavy stuffing, then a broken stuff slot
        for (int i = 0; i < 5; i++) tx_data[i] = 8'hFF;
        send_pkt(5, 1'b0, 0, "R6");
        send_pkt(5, 1'b1, 0, "R6");

        // R7: leftover partial byte makes the packet bad
        tx_data[0] = 8'h5A;
        send_pkt(1, 1'b0, 3, "R7");

        // R4 R9: full-length packet at the nominal rate, then overflows
        for (int i = 0; i < 16; i++) tx_data[i] = 8'(i * 37 + 11);
        send_pkt(MAXB, 1'b0, 0, "R4");
        send_pkt(MAXB + 1, 1'b0, 0, "R9");
        for (int i = 0; i < 16; i++) tx_data[i] = 8'hFF;
        send_pkt(15, 1'b0, 0, "R9");

        // R4 R8: random packets
        for (int p = 0; p < 20; p++) begin
            len = $urandom_range(1, MAXB);
            for (int i = 0; i < len; i++) tx_data[i] = 8'($urandom);
            send_pkt(len, 1'b0, 0, "R4");
        end

        summary();
        $finish;
    end
endmodule